// File: doc/BRIEF.md
# Spline-Modulated DDS Waveform Channel

One output lane of a multi-lane waveform synthesizer. Each clock is one sample. The lane computes an offset polynomial, an amplitude polynomial and a phase polynomial, all as functions of the sample index. It forms the sum of the offset and the amplitude times the cosine of the phase, clamps that sum to a signed 16-bit range, and then requantizes it to a 14-bit DAC code. The requantizer is a first-order noise-shaping stage, so the dropped fraction is carried forward and not lost.

Coefficients are written one at a time into a staged set. They stay there and have no effect until a trigger strobe arrives with this lane's bit set in the shared lane mask. At that edge the staged set seeds the running evaluators and the sample index restarts at zero. One strobe can therefore start many lanes in the same cycle. Between triggers the evaluators advance by additions only: each term adds the next higher difference term.

Top module: `spline_dds_chan`

## Requirements
- R1: While `rst_n` is low, `dac_code` reads 0. A reset clears every staged and running coefficient, so a trigger issued after reset with no writes produces a code of 0 on every sample.
- R2: `dac_code` is a two's-complement value. Sample n after an accepted trigger appears on `dac_code` after the (3+n)-th rising edge that follows the edge which accepted the trigger. The pre-requantization value is offset + floor(amplitude × cosine / 2^15), where offset and amplitude are bits [31:16] of their 32-bit running terms, taken as signed.
- R3: Forward-difference evaluation. With staged terms t0..t3, the offset at sample n is t0 + n·t1 + C(n,2)·t2 + C(n,3)·t3, modulo 2^32. The amplitude follows the same rule. The phase uses only t0..t2.
- R4: The cosine is indexed by the top 10 bits p of the 32-bit phase and equals round(32767·cos(2π·p/1024)), with halves rounded away from zero. A constant phase step s gives an output frequency of s/2^32 times the sample rate.
- R5: Write addresses: 0..3 are offset terms t0..t3, 4..7 are amplitude terms t0..t3, and 8..10 are phase terms t0..t2. Addresses 11..15 are ignored. A write without a trigger leaves `dac_code` unchanged.
- R6: A trigger is accepted on a rising edge only when `trig_stb` is high and bit `CH_INDEX` of `trig_mask` is set. A strobe that carries only other lanes' bits has no effect, and neither does this lane's bit without the strobe.
- R7: The sum of offset and scaled product is clamped to [-32768, 32767] and never wraps.
- R8: Requantization adds the held 2-bit residue to the 16-bit sum and shifts right by 2 with floor. The new residue is the two dropped bits. If the shifted value exceeds 8191 or falls below -8192, the output clamps to that limit and the residue is cleared. Consequently 4·code − sum always lies in [-3, 3].
- R9: A trigger accepted while the lane is running reloads all terms and restarts the sample index at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one output sample per rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a two-stage synchronizer |
| cfg_we | input | 1 | Write strobe for the staged coefficient set |
| cfg_addr | input | 4 | Selects the staged term to write (map in R5) |
| cfg_wdata | input | 32 | Coefficient value to stage |
| trig_stb | input | 1 | Trigger strobe shared by all lanes |
| trig_mask | input | NUM_CH (16) | One bit per lane; bit `CH_INDEX` selects this lane |
| dac_code | output | DAC_W (14) | Signed noise-shaped DAC code |

## Verification
A wrong term in any running evaluator shows up as a wrong code three edges after the sample that used it. Higher-order terms feed the lower ones, so a corrupted cubic or quadratic term produces an error that grows with every later sample and does not stay a single-sample glitch. A bad cosine entry affects only the phases that index it. For that reason the stimulus sweeps the phase through all four quadrants and through a non-aligned step. A residue held wrongly in the requantizer does not move the code by more than one step at a time. It shows instead as a wrong pattern of steps across four consecutive samples, and that is why sub-LSB offsets are checked sample by sample.

// File: rtl/spline_dds_pkg.sv
package spline_dds_pkg;
  localparam int COEF_W    = 32;
  localparam int COS_W     = 16;
  localparam int ADDR_W    = 4;
  localparam int OFS_TERMS = 4;
  localparam int AMP_TERMS = 4;
  localparam int PH_TERMS  = 3;

  localparam logic [ADDR_W-1:0] BASE_OFS = 4'd0;
  localparam logic [ADDR_W-1:0] BASE_AMP = 4'd4;
  localparam logic [ADDR_W-1:0] BASE_PH  = 4'd8;

  typedef logic [COEF_W-1:0] coef_t;
endpackage

// File: rtl/spline_dds_acc.sv
// Cascaded accumulators: each term adds the next-higher difference term.
module spline_dds_acc #(
  parameter int W     = 32,
  parameter int ORDER = 3
) (
  input  logic                  clk,
  input  logic                  rst_q,
  input  logic                  load,
  input  logic [ORDER:0][W-1:0] seed,
  output logic [ORDER:0][W-1:0] terms
);
  logic [ORDER:0][W-1:0] terms_nx;

  for (genvar i = 0; i <= ORDER; i++) begin : g_term
    if (i < ORDER) begin : g_chain
      assign terms_nx[i] = load ? seed[i] : terms[i] + terms[i+1];
    end else begin : g_top
      assign terms_nx[i] = load ? seed[i] : terms[i];
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) terms <= '0;
    else        terms <= terms_nx;
  end
endmodule

// File: rtl/spline_dds_cos.sv
// Full-wave cosine from a quarter-wave table built at elaboration.
module spline_dds_cos #(
  parameter int IDX_W = 10,
  parameter int OUT_W = 16
) (
  input  logic [IDX_W-1:0]        idx,
  output logic signed [OUT_W-1:0] val
);
  localparam int  QW      = IDX_W - 2;
  localparam int  QN      = 1 << QW;
  localparam real FULL    = real'((1 << (OUT_W - 1)) - 1);
  localparam real HALF_PI = 1.5707963267948966;

  logic [OUT_W-1:0] quarter [QN];

  for (genvar k = 0; k < QN; k++) begin : g_rom
    localparam int ENTRY = $rtoi(FULL * $cos(HALF_PI * real'(k) / real'(QN)) + 0.5);
    assign quarter[k] = OUT_W'(ENTRY);
  end

  logic [1:0]    quad;
  logic [QW-1:0] fine;
  logic [QW-1:0] fine_rev;

  assign quad     = idx[IDX_W-1 -: 2];
  assign fine     = idx[QW-1:0];
  assign fine_rev = QW'(0) - fine;

  always_comb begin
    unique case (quad)
      2'd0:    val = $signed(quarter[fine]);
      2'd1:    val = (fine == '0) ? '0 : -$signed(quarter[fine_rev]);
      2'd2:    val = -$signed(quarter[fine]);
      default: val = (fine == '0) ? '0 : $signed(quarter[fine_rev]);
    endcase
  end
endmodule

// File: rtl/spline_dds_shaper.sv
// First-order error-feedback requantizer with clamping.
module spline_dds_shaper #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 14
) (
  input  logic                   clk,
  input  logic                   rst_q,
  input  logic signed [IN_W-1:0] sample_in,
  output logic [OUT_W-1:0]       code_out
);
  localparam int DROP = IN_W - OUT_W;
  localparam int QW   = IN_W + 1 - DROP;
  localparam logic signed [QW-1:0] QMAX = QW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [QW-1:0] QMIN = -QMAX - QW'(1);

  logic [DROP-1:0]        resid_q, resid_nx;
  logic [OUT_W-1:0]       code_nx;
  logic signed [IN_W:0]   sum_x;
  logic signed [QW-1:0]   quot;

  always_comb begin
    sum_x = {sample_in[IN_W-1], sample_in} + {{(IN_W + 1 - DROP){1'b0}}, resid_q};
    quot  = sum_x[IN_W:DROP];
    if (quot > QMAX) begin
      code_nx  = QMAX[OUT_W-1:0];
      resid_nx = '0;
    end else if (quot < QMIN) begin
      code_nx  = QMIN[OUT_W-1:0];
      resid_nx = '0;
    end else begin
      code_nx  = quot[OUT_W-1:0];
      resid_nx = sum_x[DROP-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      resid_q  <= '0;
      code_out <= '0;
    end else begin
      resid_q  <= resid_nx;
      code_out <= code_nx;
    end
  end
endmodule

// File: rtl/spline_dds_chan.sv
module spline_dds_chan
  import spline_dds_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int CH_INDEX  = 0,
  parameter int SAMPLE_W  = 16,
  parameter int DAC_W     = 14,
  parameter int LUT_IDX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [COEF_W-1:0] cfg_wdata,
  input  logic              trig_stb,
  input  logic [NUM_CH-1:0] trig_mask,
  output logic [DAC_W-1:0]  dac_code
);
  localparam int PROD_W = SAMPLE_W + COS_W;
  localparam logic signed [PROD_W-1:0] SMAX = PROD_W'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] SMIN = -SMAX - PROD_W'(1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // staged coefficient set
  coef_t [OFS_TERMS-1:0] ofs_stage, ofs_stage_nx;
  coef_t [AMP_TERMS-1:0] amp_stage, amp_stage_nx;
  coef_t [PH_TERMS-1:0]  ph_stage,  ph_stage_nx;

  always_comb begin
    ofs_stage_nx = ofs_stage;
    amp_stage_nx = amp_stage;
    ph_stage_nx  = ph_stage;
    if (cfg_we) begin
      for (int i = 0; i < OFS_TERMS; i++)
        if (cfg_addr == BASE_OFS + ADDR_W'(i)) ofs_stage_nx[i] = cfg_wdata;
      for (int i = 0; i < AMP_TERMS; i++)
        if (cfg_addr == BASE_AMP + ADDR_W'(i)) amp_stage_nx[i] = cfg_wdata;
      for (int i = 0; i < PH_TERMS; i++)
        if (cfg_addr == BASE_PH + ADDR_W'(i)) ph_stage_nx[i] = cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ofs_stage <= '0;
      amp_stage <= '0;
      ph_stage  <= '0;
    end else begin
      ofs_stage <= ofs_stage_nx;
      amp_stage <= amp_stage_nx;
      ph_stage  <= ph_stage_nx;
    end
  end

  // trigger acceptance
  logic fire;
  assign fire = trig_stb & trig_mask[CH_INDEX];

  // running evaluators
  coef_t [OFS_TERMS-1:0] ofs_terms;
  coef_t [AMP_TERMS-1:0] amp_terms;
  coef_t [PH_TERMS-1:0]  ph_terms;

  spline_dds_acc #(.W(COEF_W), .ORDER(OFS_TERMS - 1)) ofs_acc_i (
    .clk(clk), .rst_q(rst_q), .load(fire), .seed(ofs_stage), .terms(ofs_terms));
  spline_dds_acc #(.W(COEF_W), .ORDER(AMP_TERMS - 1)) amp_acc_i (
    .clk(clk), .rst_q(rst_q), .load(fire), .seed(amp_stage), .terms(amp_terms));
  spline_dds_acc #(.W(COEF_W), .ORDER(PH_TERMS - 1)) ph_acc_i (
    .clk(clk), .rst_q(rst_q), .load(fire), .seed(ph_stage), .terms(ph_terms));

  // stage 1: cosine lookup, align offset and amplitude
  logic signed [COS_W-1:0]    cos_val;
  logic signed [COS_W-1:0]    cos_s1;
  logic signed [SAMPLE_W-1:0] ofs_s1, amp_s1;

  spline_dds_cos #(.IDX_W(LUT_IDX_W), .OUT_W(COS_W)) cos_i (
    .idx(ph_terms[0][COEF_W-1 -: LUT_IDX_W]), .val(cos_val));

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cos_s1 <= '0;
      ofs_s1 <= '0;
      amp_s1 <= '0;
    end else begin
      cos_s1 <= cos_val;
      ofs_s1 <= $signed(ofs_terms[0][COEF_W-1 -: SAMPLE_W]);
      amp_s1 <= $signed(amp_terms[0][COEF_W-1 -: SAMPLE_W]);
    end
  end

  // stage 2: product, sum, clamp
  logic signed [PROD_W-1:0]   prod, scaled, total;
  logic signed [SAMPLE_W-1:0] sum_nx, sum_q;

  always_comb begin
    prod   = amp_s1 * cos_s1;
    scaled = prod >>> (COS_W - 1);
    total  = scaled + {{(PROD_W - SAMPLE_W){ofs_s1[SAMPLE_W-1]}}, ofs_s1};
    if (total > SMAX)      sum_nx = SMAX[SAMPLE_W-1:0];
    else if (total < SMIN) sum_nx = SMIN[SAMPLE_W-1:0];
    else                   sum_nx = total[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) sum_q <= '0;
    else        sum_q <= sum_nx;
  end

  // stage 3: noise-shaped requantization
  spline_dds_shaper #(.IN_W(SAMPLE_W), .OUT_W(DAC_W)) shaper_i (
    .clk(clk), .rst_q(rst_q), .sample_in(sum_q), .code_out(dac_code));

  logic unused_bits;
  assign unused_bits = ^{ofs_terms, amp_terms, ph_terms, trig_mask};
endmodule

// File: rtl/spline_dds_chan_chk.sv
module spline_dds_chan_chk #(
  parameter int SAMPLE_W = 16,
  parameter int DAC_W    = 14
) (
  input logic                       clk,
  input logic                       rst_q,
  input logic                       fire,
  input logic [31:0]                ofs_top,
  input logic [31:0]                ofs_seed0,
  input logic [31:0]                ofs_now,
  input logic signed [SAMPLE_W-1:0] sum_q,
  input logic [DAC_W-1:0]           dac_code
);
  localparam int STEP = 1 << (SAMPLE_W - DAC_W);

  // R1: output held at zero through reset
  always @(negedge clk) begin
    if (!rst_q) begin
      assert_reset_zero_R1: assert (dac_code == '0)
        else $error("dac_code nonzero during reset");
    end
  end

  // R5: highest difference term only changes on an accepted trigger
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_q)
    !fire |=> $stable(ofs_top));

  // R6: accepted trigger seeds the running offset from the staged value
  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_q)
    fire |=> (ofs_now == $past(ofs_seed0)));

  // R8: requantized code tracks the clamped sum within the residue span
  assert_shape_R8: assert property (@(posedge clk) disable iff (!rst_q)
    ((int'($signed(dac_code)) * STEP - $past(int'(sum_q))) >= -(STEP - 1)) &&
    ((int'($signed(dac_code)) * STEP - $past(int'(sum_q))) <= (STEP - 1)));
endmodule

bind spline_dds_chan spline_dds_chan_chk #(.SAMPLE_W(SAMPLE_W), .DAC_W(DAC_W)) chk_i (
  .clk(clk), .rst_q(rst_q), .fire(fire),
  .ofs_top(ofs_terms[OFS_TERMS-1]), .ofs_seed0(ofs_stage[0]), .ofs_now(ofs_terms[0]),
  .sum_q(sum_q), .dac_code(dac_code));

// File: tb/spline_dds_chan_tb_top.sv
module spline_dds_chan_tb_top;
  localparam int NCH = 16;
  localparam int CH  = 5;
  localparam int NCF = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        trig_stb = 1'b0;
  logic [NCH-1:0] trig_mask = '0;
  logic [13:0] dac_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spline_dds_chan #(.NUM_CH(NCH), .CH_INDEX(CH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig_stb(trig_stb), .trig_mask(trig_mask),
    .dac_code(dac_code));

  // columns: offset t0..t3, amplitude t0..t3, phase t0..t2
  localparam logic [31:0] VEC [6][NCF] = '{
    '{32'h0064_0000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
    '{0, 32'h0010_0000, 32'h0008_0000, 0, 0, 0, 0, 0, 0, 0, 0},
    '{0, 0, 0, 0, 32'h1000_0000, 0, 0, 0, 0, 32'h4000_0000, 0},
    '{32'h0100_0000, 0, 0, 0, 32'h2000_0000, 0, 0, 0, 0, 32'h147A_E148, 0},
    '{0, 0, 0, 32'h0001_0000, 32'h0800_0000, 32'h0010_0000, 32'h0002_0000, 32'h0001_0000,
      32'h2000_0000, 0, 32'h0100_0000},
    '{32'h7FFF_0000, 32'h1000_0000, 0, 0, 32'h7FFF_0000, 0, 0, 0, 32'h1000_0000, 32'h0800_0000, 0}
  };

  function automatic int cos_ref(input int p);
    real x;
    x = 32767.0 * $cos(2.0 * 3.141592653589793 * real'(p) / 1024.0);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic logic [31:0] poly(input logic [31:0] t0, input logic [31:0] t1,
                                       input logic [31:0] t2, input logic [31:0] t3, input int n);
    logic [63:0] n64, k2, k3, r;
    n64 = 64'(n);
    k2  = n64 * (n64 - 64'd1) / 64'd2;
    k3  = n64 * (n64 - 64'd1) * (n64 - 64'd2) / 64'd6;
    r   = 64'(t0) + n64 * 64'(t1) + k2 * 64'(t2) + k3 * 64'(t3);
    return r[31:0];
  endfunction

  function automatic int model_sum(input logic [31:0] cf [NCF], input int n);
    logic [31:0] av, bv, cv;
    int off, amp, prod, tot;
    av   = poly(cf[0], cf[1], cf[2], cf[3], n);
    bv   = poly(cf[4], cf[5], cf[6], cf[7], n);
    cv   = poly(cf[8], cf[9], cf[10], 32'd0, n);
    off  = int'($signed(av[31:16]));
    amp  = int'($signed(bv[31:16]));
    prod = (amp * cos_ref(int'(cv[31:22]))) >>> 15;
    tot  = off + prod;
    if (tot > 32767) tot = 32767;
    if (tot < -32768) tot = -32768;
    return tot;
  endfunction

  function automatic int dac_s();
    return int'($signed(dac_code));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 output during reset", dac_s(), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_one(input int addr, input logic [31:0] data);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic write_all(input logic [31:0] cf [NCF]);
    for (int i = 0; i < NCF; i++) write_one(i, cf[i]);
  endtask

  task automatic pulse(input logic stb, input logic [NCH-1:0] mask);
    trig_stb = stb; trig_mask = mask;
    @(negedge clk);
    trig_stb = 1'b0; trig_mask = '0;
  endtask

  // accepted trigger, then wait until sample 0 is visible
  task automatic fire_own();
    pulse(1'b1, NCH'(1) << CH);
    repeat (3) @(negedge clk);
  endtask

  // residue assumed zero when sample 0 enters the requantizer
  task automatic run_samples(input logic [31:0] cf [NCF], input int count, input string req);
    int resid;
    resid = 0;
    for (int n = 0; n < count; n++) begin
      int v, q;
      if (n > 0) @(negedge clk);
      v = model_sum(cf, n) + resid;
      q = v >>> 2;
      if (q > 8191) begin q = 8191; resid = 0; end
      else if (q < -8192) begin q = -8192; resid = 0; end
      else resid = v - q * 4;
      check(req, dac_s(), q);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] cf [NCF];
    @(negedge clk);
    do_reset();
    check("R1 output after reset release", dac_s(), 0);

    // table walk: R2, R3, R4
    for (int v = 0; v < 6; v++) begin
      do_reset();
      for (int i = 0; i < NCF; i++) cf[i] = VEC[v][i];
      write_all(cf);
      fire_own();
      run_samples(cf, 6, (v < 2) ? "R3 polynomial" : (v < 4) ? "R4 phase/cosine" : "R2 composition");
    end

    // R5, R6: steady level 100, then ignored writes and triggers
    do_reset();
    for (int i = 0; i < NCF; i++) cf[i] = '0;
    cf[0] = 32'h0190_0000;
    write_all(cf);
    fire_own();
    check("R2 steady level", dac_s(), 100);
    write_one(0, 32'h0320_0000);
    write_one(12, 32'h7FFF_0000);
    repeat (5) @(negedge clk);
    check("R5 write without trigger", dac_s(), 100);
    pulse(1'b1, ~(NCH'(1) << CH));
    repeat (5) @(negedge clk);
    check("R6 other lane bits only", dac_s(), 100);
    pulse(1'b0, NCH'(1) << CH);
    repeat (5) @(negedge clk);
    check("R6 own bit without strobe", dac_s(), 100);
    pulse(1'b1, '1);
    repeat (3) @(negedge clk);
    check("R6 accepted trigger", dac_s(), 200);
    check("R5 unmapped address ignored", dac_s(), 200);

    // R7: clamp positive and negative
    do_reset();
    for (int i = 0; i < NCF; i++) cf[i] = '0;
    cf[0] = 32'h7530_0000; cf[4] = 32'h7530_0000;
    write_all(cf);
    fire_own();
    check("R7 positive clamp", dac_s(), 8191);
    run_samples(cf, 4, "R7 positive clamp");
    do_reset();
    cf[0] = 32'h8AD0_0000; cf[4] = 32'h8AD0_0000;
    write_all(cf);
    fire_own();
    check("R7 negative clamp", dac_s(), -8192);
    run_samples(cf, 3, "R7 negative clamp");

    // R8: sub-LSB offsets carried through the residue
    do_reset();
    for (int i = 0; i < NCF; i++) cf[i] = '0;
    cf[0] = 32'h0001_0000;
    write_all(cf);
    fire_own();
    run_samples(cf, 8, "R8 residue +1");
    do_reset();
    cf[0] = 32'hFFFF_0000;
    write_all(cf);
    fire_own();
    run_samples(cf, 8, "R8 residue -1");

    // R9: retrigger mid-run restarts at sample 0
    do_reset();
    for (int i = 0; i < NCF; i++) cf[i] = '0;
    cf[1] = 32'h0004_0000;
    write_all(cf);
    fire_own();
    run_samples(cf, 9, "R3 linear ramp");
    fire_own();
    check("R9 restart sample 0", dac_s(), 0);
    run_samples(cf, 4, "R9 restart ramp");

    // R1: reset mid-run clears all coefficients
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 immediate clear", dac_s(), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NCF; i++) cf[i] = '0;
    fire_own();
    run_samples(cf, 4, "R1 coefficients cleared");

    finish_run();
  end
endmodule